// File: doc/BRIEF.md
# Integer Load/Store Execute Unit

This block is the execute stage for the integer load and store instructions of a 64-bit RISC core. Each cycle it is idle it can accept one instruction: the opcode bits of the instruction word plus the three operand values already read from the register file (base, index and store data). It classifies the instruction and forms the effective address. Three addressing modes are supported: base plus a signed 12-bit offset, base plus an index register, and base plus a signed 14-bit offset scaled by four. The block then issues a single request on a valid/ready memory port. Byte enables and write-data lanes come from the access size and the low address bits.

Load data coming back from memory is shifted down to bit 0 and then sign- or zero-extended. It is returned through a registered writeback pulse. Checked variants compare base and index as unsigned 64-bit values. When the comparison fails, the block raises an address-error exception in place of the access. Prefetch and both barrier kinds retire without a data access. The data barrier waits for an external "all accesses drained" indication before it retires. Any word that matches no supported encoding raises an illegal-instruction exception.

Top module: `lsu_exec_unit`

## Requirements
- R1: Offset form: bits [31:26] = 001010 and bits [25:22] are an operation index. Index values: 0-3 are sign-extending loads of byte/half/word/double, 4-7 are stores of byte/half/word/double, 8-10 are zero-extending loads of byte/half/word, and 11 is prefetch. Index bits [1:0] give the size: 00 byte, 01 half, 10 word, 11 double. The address is base + sign-extended bits [21:10].
- R2: Indexed form: bits [31:22] = 0011100000 and bits [17:15] = 000. Bits [21:18] use the same operation index as R1, but index 11 and indices 12-15 are illegal. The address is base + index.
- R3: Scaled form: bits [31:26] = 001001, bit 24 = 1 selects store (0 selects load), and bit 25 = 1 selects double (0 selects word). The address is base + (sign-extended bits [23:10] shifted left by 2).
- R4: Checked form: bits [31:19] = 0011100001111, bit 18 selects store (1) or load (0), bit 17 selects the less-or-equal check (1) or the greater-than check (0), and bits [16:15] give the size. The address is the base alone, and loads sign-extend. The greater-than variant fails when base <= index. The less-or-equal variant fails when base > index. Both comparisons are unsigned. On failure, exc_valid pulses with exc_cause = 1 one cycle after acceptance, with no memory request, writeback or retire.
- R5: The byte enables select (1 << size) consecutive lanes starting at lane addr[2:0]. Store data is rd shifted left by 8*addr[2:0]. mem_req_we is 1 for stores and 0 for loads.
- R6: Load data is shifted right by 8*addr[2:0], then extended to 64 bits as the operation requires. It appears on wb_data, with wb_valid and retire_o high, one cycle after the cycle in which mem_rsp_valid is high.
- R7: mem_req_valid rises one cycle after acceptance. While it waits for mem_req_ready, the address, enables, write flag and data stay unchanged. A store pulses retire_o one cycle after the handshake.
- R8: in_ready is high only when the unit is idle. An instruction is accepted when in_valid and in_ready are both high.
- R9: Prefetch (R1 index 11) and the instruction barrier (bits [31:15] = 00111000011100101) pulse retire_o one cycle after acceptance and issue no request.
- R10: The data barrier (bits [31:15] = 00111000011100100) issues no request and stays busy while drain_i is low. It pulses retire_o one cycle after the first cycle in which drain_i is high.
- R11: Any other word pulses exc_valid with exc_cause = 2 one cycle after acceptance and issues no request.
- R12: After reset, in_ready = 1, and mem_req_valid, wb_valid, retire_o and exc_valid are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Unit idle and able to accept |
| in_insn | input | 22 | Instruction bits [31:10]; the register-number fields are used by the register file |
| in_rj | input | 64 | Base operand |
| in_rk | input | 64 | Index / comparison operand |
| in_rd | input | 64 | Store data operand |
| drain_i | input | 1 | All outstanding accesses have completed |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 64 | Effective address |
| mem_req_be | output | 8 | Byte-lane enables |
| mem_req_we | output | 1 | 1 for store |
| mem_req_wdata | output | 64 | Lane-aligned store data |
| mem_rsp_valid | input | 1 | Load data valid |
| mem_rsp_data | input | 64 | Load data, 8-byte aligned |
| wb_valid | output | 1 | Load result valid (pulse) |
| wb_data | output | 64 | Extended load result |
| retire_o | output | 1 | Instruction completed without exception (pulse) |
| exc_valid | output | 1 | Exception raised (pulse) |
| exc_cause | output | 2 | 1 = address error, 2 = illegal instruction |

## Verification
The bench uses the default XLEN of 64, which is the only width the encodings define. That width makes all eight byte lanes and all four access sizes reachable, including the double access that needs no extension. The bench's memory responder has a latency it sets itself. Runs with zero wait cycles cover back-to-back handshakes. Runs with several wait cycles cover the hold behaviour and the busy in_ready. The checked operands include values with the top bit set, so an unsigned comparison and a signed one would give different results.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

    typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2, SZ_DBL = 2'd3} acc_size_e;

    typedef enum logic [2:0] {
        OP_LOAD, OP_STORE, OP_PREFETCH, OP_FENCE_DATA, OP_FENCE_INSN, OP_BAD
    } op_kind_e;

    typedef enum logic [1:0] {AM_REG_IMM, AM_REG_REG, AM_REG_SCALED, AM_CHECKED} addr_mode_e;

    typedef enum logic [1:0] {CAUSE_NONE = 2'd0, CAUSE_ADDR = 2'd1, CAUSE_ILLEGAL = 2'd2} exc_cause_e;

    typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_RSP, ST_FENCE} unit_state_e;

    typedef struct packed {
        op_kind_e   kind;
        addr_mode_e mode;
        acc_size_e  size;
        logic       zext;
        logic       chk_le;
    } op_dec_t;

    localparam op_dec_t DEC_BAD = '{kind: OP_BAD, mode: AM_REG_IMM, size: SZ_BYTE,
                                    zext: 1'b0, chk_le: 1'b0};

    localparam logic [5:0]  OPC_RI   = 6'b001010;
    localparam logic [5:0]  OPC_PTR  = 6'b001001;
    localparam logic [9:0]  OPC_RR   = 10'b0011100000;
    localparam logic [12:0] OPC_CHK  = 13'b0011100001111;
    localparam logic [16:0] OPC_DBAR = 17'b00111000011100100;
    localparam logic [16:0] OPC_IBAR = 17'b00111000011100101;

    // Shared four-bit operation index used by the offset and indexed forms.
    function automatic op_dec_t classify(input logic [3:0] idx);
        op_dec_t r;
        r      = DEC_BAD;
        r.size = acc_size_e'(idx[1:0]);
        case (idx[3:2])
            2'b00: r.kind = OP_LOAD;
            2'b01: r.kind = OP_STORE;
            2'b10: begin
                if (idx[1:0] == 2'b11) begin
                    r.kind = OP_PREFETCH;
                end else begin
                    r.kind = OP_LOAD;
                    r.zext = 1'b1;
                end
            end
            default: r.kind = OP_BAD;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/lsu_decode.sv
module lsu_decode
    import lsu_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [31:10]     insn,
    output op_dec_t          dec,
    output logic [XLEN-1:0]  offset
);
    always_comb begin
        dec    = DEC_BAD;
        offset = '0;
        if (insn[31:26] == OPC_RI) begin
            dec      = classify(insn[25:22]);
            dec.mode = AM_REG_IMM;
            offset   = {{(XLEN-12){insn[21]}}, insn[21:10]};
        end else if (insn[31:26] == OPC_PTR) begin
            dec.kind = insn[24] ? OP_STORE : OP_LOAD;
            dec.size = insn[25] ? SZ_DBL : SZ_WORD;
            dec.mode = AM_REG_SCALED;
            offset   = {{(XLEN-16){insn[23]}}, insn[23:10], 2'b00};
        end else if (insn[31:22] == OPC_RR && insn[17:15] == 3'b000) begin
            dec = classify(insn[21:18]);
            if (dec.kind == OP_PREFETCH) begin
                dec.kind = OP_BAD;
            end
            dec.mode = AM_REG_REG;
        end else if (insn[31:19] == OPC_CHK) begin
            dec.kind   = insn[18] ? OP_STORE : OP_LOAD;
            dec.chk_le = insn[17];
            dec.size   = acc_size_e'(insn[16:15]);
            dec.mode   = AM_CHECKED;
        end else if (insn[31:15] == OPC_DBAR) begin
            dec.kind = OP_FENCE_DATA;
        end else if (insn[31:15] == OPC_IBAR) begin
            dec.kind = OP_FENCE_INSN;
        end
    end
endmodule

// File: rtl/lsu_agen.sv
module lsu_agen
    import lsu_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  op_dec_t         dec,
    input  logic [XLEN-1:0] base,
    input  logic [XLEN-1:0] index,
    input  logic [XLEN-1:0] offset,
    output logic [XLEN-1:0] addr,
    output logic            bound_fail
);
    logic [XLEN-1:0] addend;

    always_comb begin
        addend     = (dec.mode == AM_REG_REG) ? index : offset;
        addr       = (dec.mode == AM_CHECKED) ? base : base + addend;
        bound_fail = 1'b0;
        if (dec.mode == AM_CHECKED) begin
            bound_fail = dec.chk_le ? (base > index) : (base <= index);
        end
    end
endmodule

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes
    import lsu_pkg::*;
#(
    parameter int XLEN = 64,
    localparam int BE_W = XLEN / 8,
    localparam int LO_W = $clog2(BE_W)
) (
    input  acc_size_e       size,
    input  logic [LO_W-1:0] lo,
    input  logic [XLEN-1:0] data,
    output logic [BE_W-1:0] be,
    output logic [XLEN-1:0] wdata
);
    localparam int LW = LO_W + 2;

    logic [LW-1:0] first_lane;
    logic [LW-1:0] end_lane;

    assign first_lane = LW'(lo);
    assign end_lane   = first_lane + (LW'(1) << size);
    assign wdata      = data << {lo, 3'b000};

    for (genvar i = 0; i < BE_W; i++) begin : g_lane
        assign be[i] = (LW'(i) >= first_lane) && (LW'(i) < end_lane);
    end
endmodule

// File: rtl/lsu_load_ext.sv
module lsu_load_ext
    import lsu_pkg::*;
#(
    parameter int XLEN = 64,
    localparam int LO_W = $clog2(XLEN / 8)
) (
    input  logic [XLEN-1:0] raw,
    input  logic [LO_W-1:0] lo,
    input  acc_size_e       size,
    input  logic            zext,
    output logic [XLEN-1:0] result
);
    logic [XLEN-1:0] sh;

    assign sh = raw >> {lo, 3'b000};

    always_comb begin
        case (size)
            SZ_BYTE: result = {{(XLEN-8){~zext & sh[7]}},   sh[7:0]};
            SZ_HALF: result = {{(XLEN-16){~zext & sh[15]}}, sh[15:0]};
            SZ_WORD: result = {{(XLEN-32){~zext & sh[31]}}, sh[31:0]};
            default: result = sh;
        endcase
    end
endmodule

// File: rtl/lsu_exec_unit.sv
module lsu_exec_unit
    import lsu_pkg::*;
#(
    parameter int XLEN = 64,
    localparam int BE_W = XLEN / 8,
    localparam int LO_W = $clog2(BE_W)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [31:10]    in_insn,
    input  logic [XLEN-1:0] in_rj,
    input  logic [XLEN-1:0] in_rk,
    input  logic [XLEN-1:0] in_rd,
    input  logic            drain_i,
    output logic            mem_req_valid,
    input  logic            mem_req_ready,
    output logic [XLEN-1:0] mem_req_addr,
    output logic [BE_W-1:0] mem_req_be,
    output logic            mem_req_we,
    output logic [XLEN-1:0] mem_req_wdata,
    input  logic            mem_rsp_valid,
    input  logic [XLEN-1:0] mem_rsp_data,
    output logic            wb_valid,
    output logic [XLEN-1:0] wb_data,
    output logic            retire_o,
    output logic            exc_valid,
    output logic [1:0]      exc_cause
);
    unit_state_e     state;
    op_dec_t         dec;
    logic [XLEN-1:0] offset;
    logic [XLEN-1:0] ea;
    logic            bound_fail;
    logic [BE_W-1:0] be_n;
    logic [XLEN-1:0] wdata_n;
    logic [XLEN-1:0] ext_data;
    acc_size_e       q_size;
    logic            q_zext;
    exc_cause_e      cause_q;
    logic            accept;

    lsu_decode #(.XLEN(XLEN)) u_dec (
        .insn(in_insn), .dec(dec), .offset(offset)
    );

    lsu_agen #(.XLEN(XLEN)) u_agen (
        .dec(dec), .base(in_rj), .index(in_rk), .offset(offset),
        .addr(ea), .bound_fail(bound_fail)
    );

    lsu_store_lanes #(.XLEN(XLEN)) u_lanes (
        .size(dec.size), .lo(ea[LO_W-1:0]), .data(in_rd),
        .be(be_n), .wdata(wdata_n)
    );

    lsu_load_ext #(.XLEN(XLEN)) u_ext (
        .raw(mem_rsp_data), .lo(mem_req_addr[LO_W-1:0]), .size(q_size),
        .zext(q_zext), .result(ext_data)
    );

    assign in_ready      = (state == ST_IDLE);
    assign accept        = in_valid && in_ready;
    assign mem_req_valid = (state == ST_REQ);
    assign exc_cause     = cause_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state         <= ST_IDLE;
            wb_valid      <= 1'b0;
            wb_data       <= '0;
            retire_o      <= 1'b0;
            exc_valid     <= 1'b0;
            cause_q       <= CAUSE_NONE;
            mem_req_addr  <= '0;
            mem_req_be    <= '0;
            mem_req_we    <= 1'b0;
            mem_req_wdata <= '0;
            q_size        <= SZ_BYTE;
            q_zext        <= 1'b0;
        end else begin
            wb_valid  <= 1'b0;
            retire_o  <= 1'b0;
            exc_valid <= 1'b0;
            cause_q   <= CAUSE_NONE;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        case (dec.kind)
                            OP_LOAD, OP_STORE: begin
                                if (bound_fail) begin
                                    exc_valid <= 1'b1;
                                    cause_q   <= CAUSE_ADDR;
                                end else begin
                                    state         <= ST_REQ;
                                    mem_req_addr  <= ea;
                                    mem_req_be    <= be_n;
                                    mem_req_we    <= (dec.kind == OP_STORE);
                                    mem_req_wdata <= wdata_n;
                                    q_size        <= dec.size;
                                    q_zext        <= dec.zext;
                                end
                            end
                            OP_PREFETCH, OP_FENCE_INSN: retire_o <= 1'b1;
                            OP_FENCE_DATA:              state    <= ST_FENCE;
                            default: begin
                                exc_valid <= 1'b1;
                                cause_q   <= CAUSE_ILLEGAL;
                            end
                        endcase
                    end
                end
                ST_REQ: begin
                    if (mem_req_ready) begin
                        if (mem_req_we) begin
                            retire_o <= 1'b1;
                            state    <= ST_IDLE;
                        end else begin
                            state <= ST_RSP;
                        end
                    end
                end
                ST_RSP: begin
                    if (mem_rsp_valid) begin
                        wb_valid <= 1'b1;
                        wb_data  <= ext_data;
                        retire_o <= 1'b1;
                        state    <= ST_IDLE;
                    end
                end
                default: begin
                    if (drain_i) begin
                        retire_o <= 1'b1;
                        state    <= ST_IDLE;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/lsu_exec_unit_chk.sv
module lsu_exec_unit_chk #(
    parameter int XLEN = 64,
    localparam int BE_W = XLEN / 8
) (
    input logic            clk,
    input logic            rst,
    input logic            in_ready,
    input logic            mem_req_valid,
    input logic            mem_req_ready,
    input logic [XLEN-1:0] mem_req_addr,
    input logic [BE_W-1:0] mem_req_be,
    input logic            mem_req_we,
    input logic [XLEN-1:0] mem_req_wdata,
    input logic            mem_rsp_valid,
    input logic            wb_valid,
    input logic            retire_o,
    input logic            exc_valid,
    input logic [1:0]      exc_cause
);
    a_r7_req_hold: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
            && $stable(mem_req_be) && $stable(mem_req_we) && $stable(mem_req_wdata));

    a_r8_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> !in_ready);

    a_r4_exc_no_access: assert property (@(posedge clk) disable iff (rst)
        exc_valid |-> !wb_valid && !retire_o && !mem_req_valid);

    a_r4_cause_known: assert property (@(posedge clk) disable iff (rst)
        exc_valid |-> (exc_cause == 2'd1 || exc_cause == 2'd2));

    a_r6_wb_after_rsp: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> $past(mem_rsp_valid) && retire_o);

    a_r5_be_nonzero: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> mem_req_be != '0);
endmodule

bind lsu_exec_unit lsu_exec_unit_chk #(.XLEN(XLEN)) u_chk (
    .clk(clk), .rst(rst), .in_ready(in_ready),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_req_be(mem_req_be), .mem_req_we(mem_req_we),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .wb_valid(wb_valid), .retire_o(retire_o), .exc_valid(exc_valid),
    .exc_cause(exc_cause)
);

// File: tb/test_lsu_exec_unit.sv
module test_lsu_exec_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:10] in_insn = '0;
    logic [63:0] in_rj = '0, in_rk = '0, in_rd = '0;
    logic        drain_i = 1'b0;
    logic        mem_req_valid, mem_req_ready = 1'b0;
    logic [63:0] mem_req_addr, mem_req_wdata;
    logic [7:0]  mem_req_be;
    logic        mem_req_we;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        wb_valid, retire_o, exc_valid;
    logic [63:0] wb_data;
    logic [1:0]  exc_cause;

    int checks = 0;
    int failures = 0;
    int lat = 0;

    typedef struct packed {
        logic       wb;
        logic       ret;
        logic       exc;
        logic [1:0] cause;
        logic [63:0] data;
        int         req;
    } ev_t;

    typedef struct packed {
        logic [63:0] addr;
        logic [7:0]  be;
        logic        we;
        logic [63:0] wdata;
        int          req;
    } rq_t;

    ev_t exp_q[$];
    rq_t req_q[$];
    logic [63:0] mem [16];

    always #5 clk = ~clk;

    lsu_exec_unit i_lsu_exec_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_insn(in_insn), .in_rj(in_rj), .in_rk(in_rk), .in_rd(in_rd),
        .drain_i(drain_i), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_req_be(mem_req_be), .mem_req_we(mem_req_we),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .wb_valid(wb_valid), .wb_data(wb_data),
        .retire_o(retire_o), .exc_valid(exc_valid), .exc_cause(exc_cause)
    );

    // ---------------- encoders and reference functions ----------------
    function automatic logic [31:0] enc_ri(input logic [3:0] idx, input logic [11:0] imm);
        return {6'b001010, idx, imm, 10'd0};
    endfunction
    function automatic logic [31:0] enc_rr(input logic [3:0] idx);
        return {10'b0011100000, idx, 3'b000, 15'd0};
    endfunction
    function automatic logic [31:0] enc_ptr(input logic dbl, input logic st, input logic [13:0] imm);
        return {6'b001001, dbl, st, imm, 10'd0};
    endfunction
    function automatic logic [31:0] enc_chk(input logic st, input logic le, input logic [1:0] sz);
        return {13'b0011100001111, st, le, sz, 15'd0};
    endfunction

    function automatic logic [7:0] exp_be(input int sz, input logic [2:0] lo);
        logic [15:0] m;
        m = ((16'd1 << (16'd1 << sz)) - 16'd1) << lo;
        return m[7:0];
    endfunction

    function automatic logic [63:0] exp_load(input logic [63:0] w, input logic [2:0] lo,
                                            input int sz, input bit zx);
        logic [63:0] s;
        s = w >> (lo * 8);
        case (sz)
            0: return zx ? {56'd0, s[7:0]}  : {{56{s[7]}},  s[7:0]};
            1: return zx ? {48'd0, s[15:0]} : {{48{s[15]}}, s[15:0]};
            2: return zx ? {32'd0, s[31:0]} : {{32{s[31]}}, s[31:0]};
            default: return s;
        endcase
    endfunction

    // ---------------- driver ----------------
    task automatic send(input logic [31:0] w, input logic [63:0] a, b, d);
        @(negedge clk);
        in_insn  = w[31:10];
        in_rj    = a;
        in_rk    = b;
        in_rd    = d;
        in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wait_done;
        while (exp_q.size() != 0 || req_q.size() != 0) @(negedge clk);
    endtask

    task automatic push_ev(input bit wb, ret, exc, input logic [1:0] cause,
                           input logic [63:0] data, input int req);
        ev_t e;
        e.wb = wb; e.ret = ret; e.exc = exc; e.cause = cause; e.data = data; e.req = req;
        exp_q.push_back(e);
    endtask

    // Memory access with expected request and expected completion.
    task automatic run_mem(input logic [31:0] w, input logic [63:0] a, b, d,
                           input logic [63:0] addr, input int sz, input bit st,
                           input bit zx, input int req);
        rq_t r;
        r.addr  = addr;
        r.be    = exp_be(sz, addr[2:0]);
        r.we    = st;
        r.wdata = d << (addr[2:0] * 8);
        r.req   = req;
        req_q.push_back(r);
        push_ev(!st, 1'b1, 1'b0, 2'd0,
                st ? 64'd0 : exp_load(mem[addr[6:3]], addr[2:0], sz, zx), req);
        send(w, a, b, d);
        wait_done();
    endtask

    task automatic run_noacc(input logic [31:0] w, input logic [63:0] a, b,
                             input bit exc, input logic [1:0] cause, input int req);
        push_ev(1'b0, !exc, exc, cause, 64'd0, req);
        send(w, a, b, 64'hDEAD_BEEF_0000_0001);
        wait_done();
    endtask

    // ---------------- completion monitor (scoreboard) ----------------
    ev_t got;
    always @(negedge clk) begin
        if (!rst && (wb_valid || retire_o || exc_valid)) begin
            checks++;
            if (exp_q.size() == 0) begin
                failures++;
                $display("FAIL unexpected completion wb=%0b ret=%0b exc=%0b expected none",
                         wb_valid, retire_o, exc_valid);
            end else begin
                got = exp_q.pop_front();
                if (wb_valid !== got.wb || retire_o !== got.ret || exc_valid !== got.exc
                    || exc_cause !== got.cause || (got.wb && wb_data !== got.data)) begin
                    failures++;
                    $display("FAIL R%0d completion wb=%0b ret=%0b exc=%0b cause=%0d data=%h expected wb=%0b ret=%0b exc=%0b cause=%0d data=%h",
                             got.req, wb_valid, retire_o, exc_valid, exc_cause, wb_data,
                             got.wb, got.ret, got.exc, got.cause, got.data);
                end
            end
        end
    end

    // ---------------- memory responder ----------------
    initial begin
        int   waited;
        bit   rsp_pending;
        logic [63:0] rsp_word;
        logic [63:0] first_addr;
        rq_t  r;
        waited = 0;
        rsp_pending = 0;
        rsp_word = '0;
        first_addr = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            mem_req_ready = 1'b0;
            if (rsp_pending) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = rsp_word;
                rsp_pending   = 0;
            end else if (!rst && mem_req_valid) begin
                if (waited == 0) first_addr = mem_req_addr;
                if (waited < lat) begin
                    waited++;
                end else begin
                    mem_req_ready = 1'b1;
                    waited = 0;
                    checks++;
                    if (req_q.size() == 0) begin
                        failures++;
                        $display("FAIL unexpected request addr=%h expected none", mem_req_addr);
                    end else begin
                        r = req_q.pop_front();
                        if (mem_req_addr !== r.addr || mem_req_be !== r.be || mem_req_we !== r.we
                            || (r.we && mem_req_wdata !== r.wdata)) begin
                            failures++;
                            $display("FAIL R%0d request addr=%h be=%h we=%0b wdata=%h expected addr=%h be=%h we=%0b wdata=%h",
                                     r.req, mem_req_addr, mem_req_be, mem_req_we, mem_req_wdata,
                                     r.addr, r.be, r.we, r.wdata);
                        end
                        // R7: address unchanged across wait cycles
                        checks++;
                        if (first_addr !== mem_req_addr) begin
                            failures++;
                            $display("FAIL R7 address moved while waiting %h expected %h",
                                     mem_req_addr, first_addr);
                        end
                    end
                    if (mem_req_we) begin
                        for (int b = 0; b < 8; b++)
                            if (mem_req_be[b])
                                mem[mem_req_addr[6:3]][8*b +: 8] = mem_req_wdata[8*b +: 8];
                    end else begin
                        rsp_pending = 1;
                        rsp_word    = mem[mem_req_addr[6:3]];
                    end
                end
            end
        end
    end

    // ---------------- watchdog ----------------
    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    task automatic check1(input bit ok, input int req, input logic [63:0] act, exp_v);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL R%0d value %h expected %h", req, act, exp_v);
        end
    endtask

    // ---------------- stimulus ----------------
    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 64'h0123_4567_89AB_CDEF ^ (64'(i) << 8);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12: reset state
        check1(in_ready === 1'b1, 12, 64'(in_ready), 64'd1);
        check1(mem_req_valid === 1'b0, 12, 64'(mem_req_valid), 64'd0);
        check1({wb_valid, retire_o, exc_valid} === 3'b000, 12,
               64'({wb_valid, retire_o, exc_valid}), 64'd0);

        // R1 R5 R7: store double, offset +8, no wait
        lat = 0;
        run_mem(enc_ri(4'd7, 12'd8), 64'h1000, 64'd0, 64'hF0E0_D0C0_B0A0_9080,
                64'h1008, 3, 1'b1, 1'b0, 1);
        // R1 R6: signed byte, negative offset -5 -> lane 3 (0xB0)
        lat = 2;
        run_mem(enc_ri(4'd0, 12'hFFB), 64'h1010, 64'd0, 64'd0, 64'h100B, 0, 1'b0, 1'b0, 6);
        // R6: unsigned byte same lane
        run_mem(enc_ri(4'd8, 12'd3), 64'h1008, 64'd0, 64'd0, 64'h100B, 0, 1'b0, 1'b1, 6);
        // R6: signed / unsigned half at lane 2
        run_mem(enc_ri(4'd1, 12'd2), 64'h1008, 64'd0, 64'd0, 64'h100A, 1, 1'b0, 1'b0, 6);
        run_mem(enc_ri(4'd9, 12'd2), 64'h1008, 64'd0, 64'd0, 64'h100A, 1, 1'b0, 1'b1, 6);
        // R6: signed / unsigned word at lane 4, double
        run_mem(enc_ri(4'd2, 12'd4), 64'h1008, 64'd0, 64'd0, 64'h100C, 2, 1'b0, 1'b0, 6);
        run_mem(enc_ri(4'd10, 12'd4), 64'h1008, 64'd0, 64'd0, 64'h100C, 2, 1'b0, 1'b1, 6);
        run_mem(enc_ri(4'd3, 12'd0), 64'h1008, 64'd0, 64'd0, 64'h1008, 3, 1'b0, 1'b0, 6);

        // R8: busy while a request waits
        lat = 3;
        begin
            rq_t r;
            r.addr = 64'h1020; r.be = 8'h0F; r.we = 1'b0; r.wdata = '0; r.req = 8;
            req_q.push_back(r);
            push_ev(1'b1, 1'b1, 1'b0, 2'd0, exp_load(mem[4], 3'd0, 2, 1'b0), 8);
            send(enc_ri(4'd2, 12'd0), 64'h1020, 64'd0, 64'd0);
            check1(in_ready === 1'b0, 8, 64'(in_ready), 64'd0);
            wait_done();
        end

        // R2 R5: indexed store word at lane 4, indexed unsigned half load
        run_mem(enc_rr(4'd6), 64'h1030, 64'h4, 64'h0000_0000_8765_4321,
                64'h1034, 2, 1'b1, 1'b0, 2);
        run_mem(enc_rr(4'd9), 64'h1000, 64'h36, 64'd0, 64'h1036, 1, 1'b0, 1'b1, 2);
        run_mem(enc_rr(4'd0), 64'h1037, 64'h0, 64'd0, 64'h1037, 0, 1'b0, 1'b0, 2);

        // R3: scaled double load with offset -2 (-8 bytes), scaled store word +1 (+4)
        lat = 1;
        run_mem(enc_ptr(1'b1, 1'b0, 14'h3FFE), 64'h1048, 64'd0, 64'd0, 64'h1040, 3, 1'b0, 1'b0, 3);
        run_mem(enc_ptr(1'b0, 1'b1, 14'd1), 64'h1040, 64'd0, 64'hAAAA_5555_CAFE_F00D,
                64'h1044, 2, 1'b1, 1'b0, 3);

        // R4: checked greater-than passes with unsigned-large base
        run_mem(enc_chk(1'b0, 1'b0, 2'd3), 64'h8000_0000_0000_1010, 64'd1, 64'd0,
                64'h8000_0000_0000_1010, 3, 1'b0, 1'b0, 4);
        // R4: greater-than fails on equal operands
        run_noacc(enc_chk(1'b0, 1'b0, 2'd2), 64'h1000, 64'h1000, 1'b1, 2'd1, 4);
        // R4: less-or-equal store passes on equal, half at lane 6
        run_mem(enc_chk(1'b1, 1'b1, 2'd1), 64'h1006, 64'h1006, 64'h0000_0000_0000_BEEF,
                64'h1006, 1, 1'b1, 1'b0, 4);
        // R4: less-or-equal fails when base above index (unsigned)
        run_noacc(enc_chk(1'b1, 1'b1, 2'd0), 64'hFFFF_FFFF_FFFF_FFF0, 64'h10, 1'b1, 2'd1, 4);
        // R4: checked signed half load reads back stored value
        run_mem(enc_chk(1'b0, 1'b1, 2'd1), 64'h1006, 64'h2000, 64'd0, 64'h1006, 1, 1'b0, 1'b0, 4);

        // R9: prefetch and instruction barrier retire with no access
        run_noacc(enc_ri(4'd11, 12'h123), 64'h1000, 64'd0, 1'b0, 2'd0, 9);
        run_noacc({17'b00111000011100101, 15'h0042}, 64'd0, 64'd0, 1'b0, 2'd0, 9);

        // R10: data barrier waits for drain_i
        push_ev(1'b0, 1'b1, 1'b0, 2'd0, 64'd0, 10);
        send({17'b00111000011100100, 15'h0000}, 64'd0, 64'd0, 64'd0);
        repeat (5) @(negedge clk);
        check1(exp_q.size() == 1, 10, 64'(exp_q.size()), 64'd1);
        check1(in_ready === 1'b0, 10, 64'(in_ready), 64'd0);
        drain_i = 1'b1;
        wait_done();
        drain_i = 1'b0;

        // R11: illegal words
        run_noacc(32'hFFFF_FFFF, 64'd0, 64'd0, 1'b1, 2'd2, 11);
        run_noacc(enc_rr(4'd11), 64'h1000, 64'h8, 1'b1, 2'd2, 11);
        run_noacc(enc_rr(4'd12), 64'h1000, 64'h8, 1'b1, 2'd2, 11);
        run_noacc(enc_ri(4'd13, 12'd0), 64'h1000, 64'd0, 1'b1, 2'd2, 11);
        run_noacc(enc_rr(4'd0) | 32'h0000_8000, 64'h1000, 64'd0, 1'b1, 2'd2, 11);

        repeat (3) @(negedge clk);
        check1(exp_q.size() == 0 && req_q.size() == 0, 7,
               64'(exp_q.size() + req_q.size()), 64'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule